// File: doc/BRIEF.md
# GPIO Interrupt-On-Change Controller

This block sits next to the register file of a small port expander and watches its eight input pins. Every pin can be armed separately. An armed pin raises an interrupt in one of two ways, chosen per pin. In edge mode it fires when its sampled value differs from the value sampled one clock earlier. In level-compare mode it fires when it differs from a programmed reference bit. When the controller goes from idle to pending, it freezes a snapshot of the whole port. A flag word records which pins are responsible.

The interrupt stays pending until the register interface reports a read of the port or of the snapshot. Each read arrives as a one-cycle strobe. The interrupt pin can be driven push-pull, either active-high or active-low, or it can be driven open-drain, where it only ever pulls low.

The register interface, the serial decoding and the pin synchronizers are outside this block. The block receives already-synchronized pin values and plain write and read strobes. All ports are plain control and status signals, so there is no flow control at the edge.

Top module: `ioc_ctrl`

## Requirements
- R1: After reset, the flag word and the snapshot read zero, and the interrupt output is inactive. With the reset configuration that means push-pull active-low, so `int_o`=1 and `int_oe_o`=1.
- R2: The arm register is written at address 0, with one bit per pin. A pin whose arm bit is 0 never sets its flag, whatever it does.
- R3: The mode register is written at address 1. For a pin whose mode bit is 0 and whose arm bit is 1, a rising or a falling change between two consecutive samples sets its flag at the clock edge where the new value is sampled.
- R4: The reference register is written at address 2. For a pin whose mode bit is 1, the flag is set at every edge where the pin differs from its reference bit. While the pin equals the reference bit, no flag is set.
- R5: The snapshot takes the full port value at the edge where the flag word goes from zero to non-zero. It holds that value while flags stay pending and after they are cleared.
- R6: While flags are pending, newly firing pins are ORed into the flag word. Flags already set stay set.
- R7: A port-read strobe (`rd_port_i`) or a snapshot-read strobe (`rd_capture_i`) clears the flag word, and the interrupt goes inactive at that edge.
- R8: When a pin fires in the same cycle as a read strobe, the read removes the old flags. The firing pins then start a fresh interrupt, with a new snapshot.
- R9: Writing the arm register clears, at that edge, the flag of every pin whose new arm bit is 0.
- R10: The output configuration is written at address 3. Its bit 1 set makes the push-pull output active-high; bit 1 clear makes it active-low.
- R11: When bit 2 of the output configuration is set, the output is open-drain. `int_o` is always 0, `int_oe_o` equals "interrupt pending", and bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Synchronized pin values |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 arm, 1 mode, 2 reference, 3 output config |
| wr_data_i | input | 8 | Write data |
| rd_port_i | input | 1 | Strobe: port register was read |
| rd_capture_i | input | 1 | Strobe: snapshot register was read |
| flags_o | output | 8 | Pins that caused the pending interrupt |
| capture_o | output | 8 | Port snapshot at interrupt onset |
| int_o | output | 1 | Interrupt pin drive value |
| int_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
Some behaviour is checked on every cycle. No flag is ever set outside the arm mask. The snapshot stays still while an interrupt is pending and no read arrives. Pending flags are never dropped without a read or a write. The output pins follow the flag word for both push-pull polarities and in open-drain mode. Other behaviour only the scripted scenarios can show. That covers whether a given edge or reference mismatch fires at the right cycle, what value is captured, whether the read-collides-with-hit case restarts the interrupt, and whether disarming by a register write clears exactly the intended bits.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ARM    = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_REF    = 2'd2,
    SEL_OUTCFG = 2'd3
  } reg_sel_e;

  localparam int unsigned OUTCFG_POL_BIT = 1;
  localparam int unsigned OUTCFG_ODR_BIT = 2;

  typedef struct packed {
    logic active_high;
    logic open_drain;
  } out_cfg_t;
endpackage

// File: rtl/ioc_cfg_regs.sv
module ioc_cfg_regs
  import ioc_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  output logic [N_PINS-1:0] arm,
  output logic [N_PINS-1:0] mode,
  output logic [N_PINS-1:0] refv,
  output out_cfg_t          ocfg,
  output logic [N_PINS-1:0] disarm_mask
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  // Bits cleared by an arm write drop their pending flags in the same edge.
  assign disarm_mask = (wr_en && sel == SEL_ARM) ? ~wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm  <= '0;
      mode <= '0;
      refv <= '0;
      ocfg <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_ARM:    arm  <= wr_data;
        SEL_MODE:   mode <= wr_data;
        SEL_REF:    refv <= wr_data;
        SEL_OUTCFG: begin
          ocfg.active_high <= wr_data[OUTCFG_POL_BIT];
          ocfg.open_drain  <= wr_data[OUTCFG_ODR_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin,
  input  logic [N_PINS-1:0] arm,
  input  logic [N_PINS-1:0] mode,
  input  logic [N_PINS-1:0] refv,
  output logic [N_PINS-1:0] hit
);
  logic [N_PINS-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= pin;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic basis;
    assign basis  = mode[i] ? refv[i] : last_q[i];
    assign hit[i] = arm[i] & (pin[i] ^ basis);
  end
endmodule

// File: rtl/ioc_capture.sv
module ioc_capture #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin,
  input  logic [N_PINS-1:0] hit,
  input  logic              clear,
  input  logic [N_PINS-1:0] disarm_mask,
  output logic [N_PINS-1:0] flags,
  output logic [N_PINS-1:0] snap,
  output logic              pending
);
  logic [N_PINS-1:0] kept, flags_d;
  logic              onset;

  assign kept    = clear ? '0 : flags;
  assign flags_d = (kept | hit) & ~disarm_mask;
  assign onset   = (kept == '0) && (flags_d != '0);
  assign pending = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      flags <= flags_d;
      if (onset) snap <= pin;
    end
  end
endmodule

// File: rtl/ioc_irq_drive.sv
module ioc_irq_drive
  import ioc_pkg::*;
(
  input  logic     pending,
  input  out_cfg_t ocfg,
  output logic     int_val,
  output logic     int_oe
);
  always_comb begin
    if (ocfg.open_drain) begin
      int_val = 1'b0;
      int_oe  = pending;
    end else begin
      int_val = ocfg.active_high ? pending : ~pending;
      int_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
  import ioc_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_addr_i,
  input  logic [N_PINS-1:0] wr_data_i,
  input  logic              rd_port_i,
  input  logic              rd_capture_i,
  output logic [N_PINS-1:0] flags_o,
  output logic [N_PINS-1:0] capture_o,
  output logic              int_o,
  output logic              int_oe_o
);
  logic [N_PINS-1:0] arm, mode, refv, disarm_mask, hit;
  out_cfg_t          ocfg;
  logic              pending;

  ioc_cfg_regs #(.N_PINS(N_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .arm(arm), .mode(mode), .refv(refv),
    .ocfg(ocfg), .disarm_mask(disarm_mask)
  );

  ioc_detect #(.N_PINS(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin(pin_i), .arm(arm), .mode(mode),
    .refv(refv), .hit(hit)
  );

  ioc_capture #(.N_PINS(N_PINS)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(pin_i), .hit(hit),
    .clear(rd_port_i | rd_capture_i), .disarm_mask(disarm_mask),
    .flags(flags_o), .snap(capture_o), .pending(pending)
  );

  ioc_irq_drive u_drv (
    .pending(pending), .ocfg(ocfg), .int_val(int_o), .int_oe(int_oe_o)
  );
endmodule

// File: rtl/ioc_ctrl_chk.sv
module ioc_ctrl_chk #(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_port,
  input logic              rd_cap,
  input logic              wr_en,
  input logic [N_PINS-1:0] flags,
  input logic [N_PINS-1:0] capture,
  input logic              int_val,
  input logic              int_oe,
  input logic [N_PINS-1:0] arm,
  input logic              active_high,
  input logic              open_drain
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (flags == '0 && capture == '0));

  p_arm_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~arm) == '0);

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && !rd_port && !rd_cap) |=> $stable(capture));

  p_flags_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && !rd_port && !rd_cap && !wr_en)
      |=> ((flags & $past(flags)) == $past(flags)));

  p_push_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain |-> (int_oe && (int_val == (active_high ? (|flags) : !(|flags)))));

  p_open_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain |-> (!int_val && (int_oe == (|flags))));
endmodule

bind ioc_ctrl ioc_ctrl_chk #(.N_PINS(N_PINS)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_port(rd_port_i), .rd_cap(rd_capture_i),
  .wr_en(wr_en_i), .flags(flags_o), .capture(capture_o), .int_val(int_o),
  .int_oe(int_oe_o), .arm(arm), .active_high(ocfg.active_high),
  .open_drain(ocfg.open_drain)
);

// File: tb/test_ioc_ctrl.sv
module test_ioc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       rd_port_i = 1'b0;
  logic       rd_capture_i = 1'b0;
  logic [7:0] flags_o, capture_o;
  logic       int_o, int_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] flags;
    logic [7:0] cap;
    logic       iv;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  ioc_ctrl i_ioc_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_port_i(rd_port_i),
    .rd_capture_i(rd_capture_i), .flags_o(flags_o), .capture_o(capture_o),
    .int_o(int_o), .int_oe_o(int_oe_o)
  );

  // Monitor: compares queued expectations on the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (flags_o !== e.flags || capture_o !== e.cap ||
          int_o !== e.iv || int_oe_o !== e.oe) begin
        errors++;
        $display("FAIL %s: flags=%h/%h cap=%h/%h int=%b/%b oe=%b/%b (actual/expected)",
                 e.tag, flags_o, e.flags, capture_o, e.cap, int_o, e.iv,
                 int_oe_o, e.oe);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_now(input logic [7:0] f, input logic [7:0] c,
                            input logic iv, input logic oe, input string tag);
    exp_t e;
    e.flags = f; e.cap = c; e.iv = iv; e.oe = oe; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_now(8'h00, 8'h00, 1'b1, 1'b1, "R1 reset state under reset");
    rst_n = 1'b1;
    tick();
    expect_now(8'h00, 8'h00, 1'b1, 1'b1, "R1 reset state after release");

    // R2: unarmed pins toggle without effect
    pin_i = 8'hFF; tick();
    pin_i = 8'h00; tick();
    expect_now(8'h00, 8'h00, 1'b1, 1'b1, "R2 unarmed pins silent");

    // R3: edge mode, rising edge on pin 1
    wr(2'd0, 8'h0F);
    pin_i = 8'h02; tick();
    expect_now(8'h02, 8'h02, 1'b0, 1'b1, "R3 rising edge fires");

    // R6/R5: second pin ORs in, snapshot held
    pin_i = 8'h06; tick();
    expect_now(8'h06, 8'h02, 1'b0, 1'b1, "R6 flags accumulate, R5 snapshot held");
    pin_i = 8'h16; tick();
    expect_now(8'h06, 8'h02, 1'b0, 1'b1, "R2 unarmed pin 4 ignored while pending");

    // R7: port read clears
    rd_port_i = 1'b1; tick(); rd_port_i = 1'b0;
    expect_now(8'h00, 8'h02, 1'b1, 1'b1, "R7 port read clears, R5 snapshot kept");

    // R4: reference compare
    wr(2'd2, 8'h06);
    wr(2'd1, 8'h0F);
    tick();
    expect_now(8'h00, 8'h02, 1'b1, 1'b1, "R4 pins equal reference do not fire");
    pin_i = 8'h17; tick();
    expect_now(8'h01, 8'h17, 1'b0, 1'b1, "R4 mismatch vs reference fires");
    tick();
    expect_now(8'h01, 8'h17, 1'b0, 1'b1, "R4 mismatch keeps flag set");

    // R8: snapshot read collides with persistent mismatch
    rd_capture_i = 1'b1; tick(); rd_capture_i = 1'b0;
    expect_now(8'h01, 8'h17, 1'b0, 1'b1, "R8 read plus hit restarts interrupt");

    // R9: disarm pin 0 by register write
    wr(2'd0, 8'h0E);
    expect_now(8'h00, 8'h17, 1'b1, 1'b1, "R9 disarm clears flag");

    // R10: active-high push-pull
    pin_i = 8'h16; tick();
    wr(2'd3, 8'h02);
    expect_now(8'h00, 8'h17, 1'b0, 1'b1, "R10 active-high idle low");
    pin_i = 8'h14; tick();
    expect_now(8'h02, 8'h14, 1'b1, 1'b1, "R10 active-high asserted");

    // R11: open drain, polarity bit ignored
    wr(2'd3, 8'h06);
    expect_now(8'h02, 8'h14, 1'b0, 1'b1, "R11 open-drain pulls low when pending");
    pin_i = 8'h16; rd_port_i = 1'b1; tick(); rd_port_i = 1'b0;
    expect_now(8'h00, 8'h14, 1'b0, 1'b0, "R11 open-drain released when idle");

    // R3: falling edge in edge mode
    wr(2'd1, 8'h00);
    expect_now(8'h00, 8'h14, 1'b0, 1'b0, "R3 no edge, no flag");
    pin_i = 8'h12; tick();
    expect_now(8'h04, 8'h12, 1'b0, 1'b1, "R3 falling edge fires");

    @(negedge clk);
    #1;
    done = 1;
    finish_run();
  end
endmodule